// File: doc/BRIEF.md
# Row-Oriented Write Buffer for a Serial EEPROM

This block collects the data bytes of one serial-bus write command and holds them until the command is closed. Before the first data byte, the protocol engine loads a start address and the state of the mode pin. Each byte strobe then stores one byte in a slot. The slot's target address depends on the addressing mode. In row mode, the low three address bits advance and wrap inside one eight-byte row. In span mode, the full address advances, so the bytes may cross into the following row.

A commit strobe closes the command, and the array sees nothing before it. On commit, the block runs a timed program cycle and raises busy for one or two row times. During the first cycles of the program cycle it replays the latched slots onto the array write port, one per clock, in ascending slot order. Each slot's target address appears on a check output before the slot is written. The protection logic outside the block answers with an inhibit input, which blocks that one write. A write-lock input sampled at commit discards the command without any program cycle. An abort (a new START before STOP) discards the buffer. A build without span mode treats every command as row mode.

Top module: `ee_row_wbuf`

## Requirements
- R1: In row mode, byte k of a command (k counted from 0) targets the start row, at low offset (start[2:0] + k) mod 8. The upper address bits stay those of the start address.
- R2: In span mode, byte k targets (start + k) mod 2^ADDR_W. If the first and last targeted addresses lie in different rows, two_rows_o is 1 while busy and the program cycle lasts 2*ROW_TICKS cycles. Otherwise two_rows_o is 0 and it lasts ROW_TICKS cycles.
- R3: A span-mode command of 8 bytes whose start address has low bits 000 writes all eight bytes of that one row, in a single row time.
- R4: A command with one data byte writes that byte at the start address with a single row time, whatever the mode input.
- R5: The buffer has 8 slots. Byte k goes to slot k mod 8, and a later byte replaces an earlier one in the same slot. The array receives at most one write per slot, carrying the last byte stored there.
- R6: If wr_lock_i is 1 in the commit cycle, no array write occurs, busy_o stays 0, and the buffer is emptied.
- R7: With HAS_MULTI = 0, the mode input is ignored and every command behaves as in R1, with two_rows_o always 0.
- R8: arr_we_o stays 0 until a commit. A commit with no byte stored since the last start or clear starts no program cycle.
- R9: busy_o rises in the cycle after the commit edge and stays high for exactly ROW_TICKS or 2*ROW_TICKS cycles. Array writes occur only while busy_o is 1, in ascending slot order.
- R10: An abort strobe empties the buffer, so a following commit writes nothing.
- R11: While busy_o is 1, the start, byte, commit and abort strobes are ignored. The buffer is emptied when the program cycle ends.
- R12: If inhibit_i is 1 while chk_addr_o shows a slot's address during the replay, that slot is not written to the array.
- R13: After reset, busy_o, arr_we_o and two_rows_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Addressing mode, captured at start: 1 = span mode, 0 = row mode |
| wr_lock_i | input | 1 | Write lock, sampled with the commit strobe |
| start_i | input | 1 | Load the start address and mode; empties the buffer |
| start_addr_i | input | ADDR_W | Start address of the command |
| byte_i | input | 1 | Data byte strobe |
| byte_data_i | input | DATA_W | Data byte |
| commit_i | input | 1 | Close the command (bus STOP) |
| abort_i | input | 1 | Discard the command (START before STOP) |
| inhibit_i | input | 1 | Protection answer for the address on chk_addr_o |
| chk_addr_o | output | ADDR_W | Address of the slot being replayed |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Program cycle in progress |
| two_rows_o | output | 1 | Current program cycle spans two rows |

## Verification
The bench sweeps every start offset within a row, with command lengths from one to ten bytes, in both modes. Span-mode commands start in the last row of the address space, so they also cover the wrap of the full address. A design that incremented the full address in row mode would write into the next row. One that kept only four bytes in span mode would lose an aligned eight-byte row, and a wrong row-crossing test would show up as a wrong busy length or a wrong two_rows_o. Overlong commands expose a buffer that keeps the first byte of a slot instead of the last. Lock, abort, empty-commit, busy-time strobes and a protected tail of a row each check for a stray array write or a stray program cycle.

// File: rtl/ee_wbuf_pkg.sv
package ee_wbuf_pkg;
  typedef enum logic {
    WB_IDLE = 1'b0,
    WB_PROG = 1'b1
  } wb_state_e;
endpackage

// File: rtl/ee_wbuf_addr.sv
// Maps a slot index to its array address for the captured mode.
module ee_wbuf_addr #(
  parameter int ADDR_W    = 9,
  parameter int ROW_BYTES = 8,
  localparam int RB       = $clog2(ROW_BYTES)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic              span_i,
  input  logic [RB-1:0]     idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [RB-1:0] low_wrap;

  always_comb begin
    low_wrap = base_i[RB-1:0] + idx_i;
    if (span_i) addr_o = base_i + ADDR_W'(idx_i);
    else        addr_o = {base_i[ADDR_W-1:RB], low_wrap};
  end
endmodule

// File: rtl/ee_wbuf_slots.sv
// Eight-slot (ROW_BYTES) byte store with per-slot valid flags.
module ee_wbuf_slots #(
  parameter int DATA_W    = 8,
  parameter int ROW_BYTES = 8,
  localparam int RB       = $clog2(ROW_BYTES),
  localparam int CW       = RB + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [RB-1:0]     rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [CW-1:0]     count_o
);
  logic [DATA_W-1:0]    mem [ROW_BYTES];
  logic [ROW_BYTES-1:0] valid_q;
  logic [RB-1:0]        ptr_q;
  logic [CW-1:0]        cnt_q;

  always_ff @(posedge clk) begin
    if (wr_i && !clr_i) mem[ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      valid_q <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else if (wr_i) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q          <= ptr_q + 1'b1;
      if (cnt_q != CW'(ROW_BYTES)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rd_data_o  = mem[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];
  assign count_o    = cnt_q;

  // R5: never more than one row of bytes is held
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(ROW_BYTES));
  // R5: valid flags and byte count agree
  p_valid_count_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_q) == int'(cnt_q));
endmodule

// File: rtl/ee_wbuf_seq.sv
// Program-cycle timer and slot replay sequencer.
module ee_wbuf_seq
  import ee_wbuf_pkg::*;
#(
  parameter int ROW_BYTES = 8,
  parameter int ROW_TICKS = 16,
  localparam int RB       = $clog2(ROW_BYTES),
  localparam int TW       = $clog2(2 * ROW_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic          two_rows_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          scan_o,
  output logic [RB-1:0] scan_idx_o,
  output logic          two_rows_o
);
  wb_state_e     state_q;
  logic [TW-1:0] tmr_q;
  logic          scan_q;
  logic [RB-1:0] idx_q;
  logic          two_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WB_IDLE;
      tmr_q   <= '0;
      scan_q  <= 1'b0;
      idx_q   <= '0;
      two_q   <= 1'b0;
    end else begin
      case (state_q)
        WB_IDLE: if (go_i) begin
          state_q <= WB_PROG;
          tmr_q   <= two_rows_i ? TW'(2 * ROW_TICKS - 1) : TW'(ROW_TICKS - 1);
          scan_q  <= 1'b1;
          idx_q   <= '0;
          two_q   <= two_rows_i;
        end
        WB_PROG: begin
          if (scan_q) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == RB'(ROW_BYTES - 1)) scan_q <= 1'b0;
          end
          if (tmr_q == '0) begin
            state_q <= WB_IDLE;
            two_q   <= 1'b0;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: state_q <= WB_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == WB_PROG);
  assign done_o     = busy_o && (tmr_q == '0);
  assign scan_o     = scan_q;
  assign scan_idx_o = idx_q;
  assign two_rows_o = two_q;

  // R9: slot replay finishes inside the program cycle
  p_scan_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
    scan_q |-> busy_o);
  // R2: row-count flag holds for the whole cycle
  p_two_stable_r2: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) |-> $stable(two_q));
endmodule

// File: rtl/ee_row_wbuf.sv
module ee_row_wbuf #(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 8,
  parameter int ROW_BYTES = 8,
  parameter int ROW_TICKS = 16,
  parameter bit HAS_MULTI = 1'b1,
  localparam int RB       = $clog2(ROW_BYTES),
  localparam int CW       = RB + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              wr_lock_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic              inhibit_i,
  output logic [ADDR_W-1:0] chk_addr_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  output logic              busy_o,
  output logic              two_rows_o
);
  logic [ADDR_W-1:0] base_q;
  logic              mode_q;
  logic              span;
  logic              busy, done, scan;
  logic [RB-1:0]     scan_idx;
  logic [CW-1:0]     count;
  logic [RB-1:0]     last_idx;
  logic [ADDR_W-1:0] scan_addr, last_addr;
  logic [DATA_W-1:0] slot_data;
  logic              slot_valid;
  logic              take_abort, take_start, take_commit, take_byte;
  logic              go, clr, two_rows_next;
  logic              we_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  generate
    if (HAS_MULTI) begin : g_span
      assign span = mode_q;
    end else begin : g_row_only
      assign span = 1'b0;
    end
  endgenerate

  // strobe arbitration, all ignored while programming
  always_comb begin
    take_abort  = !busy && abort_i;
    take_start  = !busy && !abort_i && start_i;
    take_commit = !busy && !abort_i && !start_i && commit_i;
    take_byte   = !busy && !abort_i && !start_i && !commit_i && byte_i;
    go          = take_commit && (count != '0) && !wr_lock_i;
    clr         = take_abort || take_start || (take_commit && !go) || done;
    last_idx    = RB'(count - 1'b1);
    two_rows_next = span && (last_addr[ADDR_W-1:RB] != base_q[ADDR_W-1:RB]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mode_q <= 1'b0;
    end else if (take_start) begin
      base_q <= start_addr_i;
      mode_q <= mode_i;
    end
  end

  ee_wbuf_slots #(.DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES)) slots_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .wr_i       (take_byte),
    .wr_data_i  (byte_data_i),
    .rd_idx_i   (scan_idx),
    .rd_data_o  (slot_data),
    .rd_valid_o (slot_valid),
    .count_o    (count)
  );

  ee_wbuf_addr #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) scan_map_i (
    .base_i (base_q),
    .span_i (span),
    .idx_i  (scan_idx),
    .addr_o (scan_addr)
  );

  ee_wbuf_addr #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) last_map_i (
    .base_i (base_q),
    .span_i (span),
    .idx_i  (last_idx),
    .addr_o (last_addr)
  );

  ee_wbuf_seq #(.ROW_BYTES(ROW_BYTES), .ROW_TICKS(ROW_TICKS)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .go_i       (go),
    .two_rows_i (two_rows_next),
    .busy_o     (busy),
    .done_o     (done),
    .scan_o     (scan),
    .scan_idx_o (scan_idx),
    .two_rows_o (two_rows_o)
  );

  // registered array write port
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q    <= scan && slot_valid && !inhibit_i;
      waddr_q <= scan_addr;
      wdata_q <= slot_data;
    end
  end

  assign chk_addr_o  = scan_addr;
  assign arr_we_o    = we_q;
  assign arr_addr_o  = waddr_q;
  assign arr_wdata_o = wdata_q;
  assign busy_o      = busy;

  // R9: array writes only inside a program cycle
  p_we_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> busy_o);
  // R6: a locked commit from idle starts nothing
  p_lock_no_busy_r6: assert property (@(posedge clk) disable iff (rst)
    commit_i && wr_lock_i && !busy_o |=> !busy_o);
  // R8: an empty commit starts nothing
  p_empty_commit_r8: assert property (@(posedge clk) disable iff (rst)
    commit_i && !busy_o && (count == '0) |=> !busy_o);
  // R2: the two-row flag only shows during a program cycle
  p_two_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
    two_rows_o |-> busy_o);
endmodule

// File: tb/ee_row_wbuf_tb.sv
module ee_row_wbuf_tb_top;
  localparam int AW = 9;
  localparam int RT = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0, lock = 1'b0, start = 1'b0, bstb = 1'b0;
  logic commit = 1'b0, abort = 1'b0;
  logic [AW-1:0] saddr = '0;
  logic [7:0] bdata = '0;
  logic inh_en = 1'b0;
  logic [AW-1:0] inh_lo = '1;

  logic [AW-1:0] chk0, chk1, wa0, wa1;
  logic we0, we1, busy0, busy1, two0, two1;
  logic [7:0] wd0, wd1;
  logic inh0, inh1;

  assign inh0 = inh_en && (chk0 >= inh_lo);
  assign inh1 = inh_en && (chk1 >= inh_lo);

  always #2 clk = ~clk;

  ee_row_wbuf #(.ADDR_W(AW), .ROW_TICKS(RT), .HAS_MULTI(1'b1)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode), .wr_lock_i(lock), .start_i(start),
    .start_addr_i(saddr), .byte_i(bstb), .byte_data_i(bdata), .commit_i(commit),
    .abort_i(abort), .inhibit_i(inh0), .chk_addr_o(chk0), .arr_we_o(we0),
    .arr_addr_o(wa0), .arr_wdata_o(wd0), .busy_o(busy0), .two_rows_o(two0));

  ee_row_wbuf #(.ADDR_W(AW), .ROW_TICKS(RT), .HAS_MULTI(1'b0)) dut_p_i (
    .clk(clk), .rst(rst), .mode_i(mode), .wr_lock_i(lock), .start_i(start),
    .start_addr_i(saddr), .byte_i(bstb), .byte_data_i(bdata), .commit_i(commit),
    .abort_i(abort), .inhibit_i(inh1), .chk_addr_o(chk1), .arr_we_o(we1),
    .arr_addr_o(wa1), .arr_wdata_o(wd1), .busy_o(busy1), .two_rows_o(two1));

  int tests = 0, fails = 0;
  int wcnt [2];
  int bcnt [2];
  logic two_seen [2];
  logic [AW-1:0] la [2][16];
  logic [7:0] ld [2][16];

  always @(negedge clk) begin
    if (!rst) begin
      if (we0) begin
        if (wcnt[0] < 16) begin la[0][wcnt[0]] = wa0; ld[0][wcnt[0]] = wd0; end
        wcnt[0]++;
      end
      if (we1) begin
        if (wcnt[1] < 16) begin la[1][wcnt[1]] = wa1; ld[1][wcnt[1]] = wd1; end
        wcnt[1]++;
      end
      if (busy0) bcnt[0]++;
      if (busy1) bcnt[1]++;
      if (two0) two_seen[0] = 1'b1;
      if (two1) two_seen[1] = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    for (int k = 0; k < 2; k++) begin
      wcnt[k] = 0; bcnt[k] = 0; two_seen[k] = 1'b0;
    end
  endtask

  function automatic logic [7:0] dpat(input logic [AW-1:0] base, input int i);
    return 8'(base[7:0] ^ 8'(i * 37 + 5));
  endfunction

  task automatic check_inst(input int k, input bit mm, input logic [AW-1:0] base,
                            input int n, input bit lk, input string tag);
    int m, ew, li, eb;
    bit two;
    logic [AW-1:0] ea, lasta;
    m = (n > 8) ? 8 : n;
    ew = 0;
    for (int s = 0; s < 8; s++) begin
      if (s >= m || lk) continue;
      ea = mm ? AW'(base + AW'(s)) : {base[AW-1:3], 3'(base[2:0] + 3'(s))};
      if (inh_en && ea >= inh_lo) continue;
      li = s + 8 * ((n - 1 - s) / 8);
      if (ew < wcnt[k] && ew < 16) begin
        chk(la[k][ew] == ea, tag, int'(la[k][ew]), int'(ea));
        chk(ld[k][ew] == dpat(base, li), tag, int'(ld[k][ew]), int'(dpat(base, li)));
      end
      ew++;
    end
    chk(wcnt[k] == ew, tag, wcnt[k], ew);
    lasta = AW'(base + AW'(m - 1));
    two = mm && (m > 0) && !lk && (lasta[AW-1:3] != base[AW-1:3]);
    eb = (lk || n == 0) ? 0 : RT * (two ? 2 : 1);
    chk(bcnt[k] == eb, "R9", bcnt[k], eb);
    chk(two_seen[k] == two, "R2", int'(two_seen[k]), int'(two));
  endtask

  task automatic load(input bit mm, input logic [AW-1:0] base, input int n);
    @(negedge clk); mode = mm; start = 1'b1; saddr = base;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < n; i++) begin
      bstb = 1'b1; bdata = dpat(base, i);
      @(negedge clk);
    end
    bstb = 1'b0;
  endtask

  task automatic fire(input bit lk);
    commit = 1'b1; lock = lk;
    @(negedge clk); commit = 1'b0; lock = 1'b0;
    repeat (2 * RT + 4) @(negedge clk);
  endtask

  task automatic txn(input bit mm, input logic [AW-1:0] base, input int n,
                     input bit lk, input string tag);
    clear_logs();
    load(mm, base, n);
    chk(wcnt[0] == 0, "R8", wcnt[0], 0);
    fire(lk);
    check_inst(0, mm, base, n, lk, tag);
    check_inst(1, 1'b0, base, n, lk, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_logs();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13: reset state
    chk(!busy0 && !we0 && !two0, "R13", int'({busy0, we0, two0}), 0);

    // sweep: both modes, every start offset, 1..10 bytes (R1 R2 R4 R5)
    for (int mm = 0; mm < 2; mm++)
      for (int off = 0; off < 8; off++)
        for (int n = 1; n <= 10; n++)
          txn(mm[0], (mm != 0) ? AW'(9'h1F8 + off) : AW'(9'h138 + off), n, 1'b0,
              (n > 8) ? "R5" : (n == 1) ? "R4" : (mm != 0) ? "R2" : "R1");

    // R3: aligned full row in span mode
    txn(1'b1, 9'h048, 8, 1'b0, "R3");
    // R4: single byte, span mode at a row end
    txn(1'b1, 9'h0A7, 1, 1'b0, "R4");
    // R6: write lock
    txn(1'b1, 9'h0A6, 4, 1'b1, "R6");
    txn(1'b0, 9'h020, 8, 1'b1, "R6");

    // R8: commit with no bytes
    clear_logs();
    load(1'b0, 9'h010, 0);
    fire(1'b0);
    chk(wcnt[0] == 0 && bcnt[0] == 0, "R8", wcnt[0] + bcnt[0], 0);

    // R10: abort discards the buffer
    clear_logs();
    load(1'b0, 9'h010, 3);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    fire(1'b0);
    chk(wcnt[0] == 0 && bcnt[0] == 0, "R10", wcnt[0] + bcnt[0], 0);

    // R11: strobes during busy are ignored, buffer empty afterwards
    clear_logs();
    load(1'b0, 9'h040, 2);
    commit = 1'b1; @(negedge clk); commit = 1'b0;
    start = 1'b1; saddr = 9'h080; @(negedge clk); start = 1'b0;
    bstb = 1'b1; bdata = 8'h5A; @(negedge clk); bstb = 1'b0;
    commit = 1'b1; @(negedge clk); commit = 1'b0;
    repeat (2 * RT + 4) @(negedge clk);
    check_inst(0, 1'b0, 9'h040, 2, 1'b0, "R11");
    clear_logs();
    fire(1'b0);
    chk(wcnt[0] == 0 && bcnt[0] == 0, "R11", wcnt[0] + bcnt[0], 0);

    // R12: protected tail of a row
    inh_en = 1'b1; inh_lo = 9'h1FC;
    txn(1'b0, 9'h1F8, 8, 1'b0, "R12");
    txn(1'b1, 9'h1FA, 4, 1'b0, "R12");
    inh_en = 1'b0; inh_lo = '1;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule